// File: doc/BRIEF.md
# Halt Group Cross-Trigger

This block ties harts and external trigger lines together into numbered halt groups. Each hart and each trigger line carries a 5-bit group number on a configuration port, and that number can change at any time. When a hart in a nonzero group starts to report halted, or an incoming trigger pulse arrives on a line in a nonzero group, every running hart in that group gets a halt request. The request is held until the hart reports halted. A hart halting also produces a one-cycle pulse on every outgoing trigger line in its group.

Group 0 is the "no group" setting. Harts and triggers in group 0 neither cause nor receive any cross-halting. A group event can land on a hart that is still reporting halted because it is in the middle of a group-wide resume. Such a hart gets a short re-arm window. If it drops its halted flag inside that window, it is sent a halt request, so the whole group ends up halted again.

Top module: `halt_xtrig`

## Requirements
- R1: After a synchronous active-low reset, `halt_req_o` and `trig_out_o` are all zero. A hart that is already halted while reset is applied does not count as a new halt once reset is released.
- R2: If hart `s` in nonzero group `g` changes from not-halted to halted, every other non-halted hart whose group is `g` sees `halt_req_o` high two rising edges after the input change. Harts in any other group see no request.
- R3: Once raised, a hart's halt request stays high while that hart's halted input is low. It drops at the first rising edge at which that hart's halted input is high.
- R4: A high level on `trig_in_i[t]`, sampled at a rising edge, counts as one trigger event for group `trig_group_i[t]`. Two edges later, every non-halted hart in that nonzero group sees `halt_req_o` high. A trigger input never drives any `trig_out_o`.
- R5: A halt event from a hart in nonzero group `g` drives `trig_out_o[t]` high for exactly one cycle, on the same edge as the halt requests of R2, for every trigger line `t` whose group is `g`.
- R6: A hart or trigger whose group field is 0 takes no part in cross-halting: its own events request nothing, and no event ever requests it.
- R7: Changing a group assignment never creates a request by itself. Moving a running hart into a group whose members are already halted leaves its request low.
- R8: A group event that reaches a hart whose halted input is high arms a re-arm window of `REARM_CYC` edges. If that hart's halted input is sampled low at one of the next `REARM_CYC` rising edges, its halt request goes high at that edge. If its halted input stays high longer than that, no request follows.
- R9: A hart's own halt event never requests that hart. A hart that stays halted never shows a halt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hart_group_i | input | NUM_HARTS*5 | Group number of each hart, hart h in bits [5h+4:5h] |
| trig_group_i | input | NUM_TRIG*5 | Group number of each trigger line, line t in bits [5t+4:5t] |
| hart_halted_i | input | NUM_HARTS | Halted status from each hart |
| trig_in_i | input | NUM_TRIG | Incoming external trigger pulses |
| halt_req_o | output | NUM_HARTS | Group halt request toward each hart |
| trig_out_o | output | NUM_TRIG | Outgoing external trigger pulses |

## Verification
The hardest case to reach from the ports is the resume race. A group event has to arrive while the target hart still reports halted, and the target then has to drop halted either inside or just outside the re-arm window. To set this up, the bench halts the target while it sits in group 0, so that no event is produced. It then moves the target into the group, which also exercises R7. Next it halts a second member, and it releases the target's halted flag at a chosen number of edges after the event. The remaining stimulus sweeps group patterns arithmetically: every source hart and every trigger line is tried under each pattern, with a reset between trials.

// File: rtl/hx_pkg.sv
// Shared types for the halt group cross-trigger.
// Assumes group numbers are a fixed 5-bit field and that 0 means "no group".
package hx_pkg;
    localparam int HX_GRP_W = 5;
    typedef logic [HX_GRP_W-1:0] hx_grp_t;
    localparam hx_grp_t HX_SOLO_GRP = '0;
endpackage

// File: rtl/hx_edge.sv
// Halt edge detector and trigger input register.
// Turns each hart's halted level into a one-cycle registered rise event.
// Registers the incoming trigger lines.
// Assumes halted inputs are synchronous to clk. During reset the previous
// halted value follows the input, so harts halted across reset make no event.
module hx_edge #(
    parameter int NUM_HARTS = 4,
    parameter int NUM_TRIG  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_HARTS-1:0] halted_i,
    input  logic [NUM_TRIG-1:0]  trig_i,
    output logic [NUM_HARTS-1:0] rise_o,
    output logic [NUM_TRIG-1:0]  trig_o
);
    logic [NUM_HARTS-1:0] halted_d;
    logic [NUM_HARTS-1:0] rise_q;
    logic [NUM_TRIG-1:0]  tin_q;

    // Track previous halted level and register rise events and trigger inputs.
    always_ff @(posedge clk) begin
        halted_d <= halted_i;
        if (!rst_n) begin
            rise_q <= '0;
            tin_q  <= '0;
        end else begin
            rise_q <= halted_i & ~halted_d;
            tin_q  <= trig_i;
        end
    end

    assign rise_o = rise_q;
    assign trig_o = tin_q;

    // A rise event never repeats on consecutive cycles for the same hart.
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_q & $past(rise_q)) == '0)); // R2

endmodule

// File: rtl/hx_match.sv
// Group matcher: compares group numbers of event sources against each target.
// hit_o[h]  : some other hart or trigger in hart h's nonzero group fired.
// fire_o[t] : some hart in trigger t's nonzero group produced a halt event.
// Assumes events are one-cycle registered pulses. Purely combinational
// except for the clock used by its assertions.
module hx_match
    import hx_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int NUM_TRIG  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_HARTS*HX_GRP_W-1:0] hart_grp_i,
    input  logic [NUM_TRIG*HX_GRP_W-1:0]  trig_grp_i,
    input  logic [NUM_HARTS-1:0]          rise_i,
    input  logic [NUM_TRIG-1:0]           tin_i,
    output logic [NUM_HARTS-1:0]          hit_o,
    output logic [NUM_TRIG-1:0]           fire_o
);
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        hx_grp_t my_grp;
        assign my_grp = hart_grp_i[h*HX_GRP_W +: HX_GRP_W];

        // Collect events from other harts and from triggers in this hart's group.
        always_comb begin
            hit_o[h] = 1'b0;
            for (int k = 0; k < NUM_HARTS; k++) begin
                if (k != h && rise_i[k] &&
                    hart_grp_i[k*HX_GRP_W +: HX_GRP_W] == my_grp)
                    hit_o[h] = 1'b1;
            end
            for (int t = 0; t < NUM_TRIG; t++) begin
                if (tin_i[t] && trig_grp_i[t*HX_GRP_W +: HX_GRP_W] == my_grp)
                    hit_o[h] = 1'b1;
            end
            if (my_grp == HX_SOLO_GRP)
                hit_o[h] = 1'b0;
        end

        // A hart in group 0 is never targeted.
        AST_SOLO_HART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (my_grp == HX_SOLO_GRP) |-> !hit_o[h]); // R6
    end

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
        hx_grp_t tg;
        assign tg = trig_grp_i[t*HX_GRP_W +: HX_GRP_W];

        // Signal this trigger line when a hart in its group halted.
        always_comb begin
            fire_o[t] = 1'b0;
            for (int k = 0; k < NUM_HARTS; k++) begin
                if (rise_i[k] && hart_grp_i[k*HX_GRP_W +: HX_GRP_W] == tg)
                    fire_o[t] = 1'b1;
            end
            if (tg == HX_SOLO_GRP)
                fire_o[t] = 1'b0;
        end

        // Nothing fires an outgoing line without a hart halt event.
        AST_FIRE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            fire_o[t] |-> (rise_i != '0)); // R5
    end

endmodule

// File: rtl/hx_target.sv
// Per-hart halt request holder with resume-race re-arm window.
// A hit on a running hart raises the request, which is held until the hart
// reports halted. A hit on a halted hart loads a countdown. If the hart
// drops halted while the countdown is nonzero, the request is raised.
// Assumes a resuming hart clears its halted flag within REARM_CYC cycles.
module hx_target #(
    parameter int REARM_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic halted_i,
    output logic req_o
);
    localparam int CNT_W = $clog2(REARM_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REARM_CYC);

    logic             req_q, req_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    // Next-state rules for request and re-arm countdown.
    always_comb begin
        req_n = req_q;
        cnt_n = cnt_q;
        if (cnt_q != '0)
            cnt_n = cnt_q - CNT_W'(1);
        if (halted_i)
            req_n = 1'b0;
        if (cnt_q != '0 && !halted_i) begin
            req_n = 1'b1;
            cnt_n = '0;
        end
        if (hit_i) begin
            if (halted_i)
                cnt_n = CNT_LOAD;
            else
                req_n = 1'b1;
        end
    end

    // Request and countdown registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            req_q <= req_n;
            cnt_q <= cnt_n;
        end
    end

    assign req_o = req_q;

    // Halted input seen at an edge always drops the request.
    AST_REQ_DROPS_ON_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        halted_i |=> !req_q); // R3
    // A request on a running hart is held.
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !halted_i) |=> req_q); // R3
    // A request appears only after a hit or during an armed window.
    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_q ##1 req_q |-> $past(hit_i) || ($past(cnt_q) != '0)); // R8
    // The window is only armed while the hart was halted.
    AST_WIN_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $past(halted_i)); // R8

endmodule

// File: rtl/halt_xtrig.sv
// Halt group cross-trigger top.
// Detects hart halt edges and trigger pulses, matches them by group number,
// drives held halt requests to harts and one-cycle pulses to trigger outputs.
// Assumes all inputs are synchronous to clk and group fields are 5 bits.
module halt_xtrig
    import hx_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int NUM_TRIG  = 2,
    parameter int REARM_CYC = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_HARTS*HX_GRP_W-1:0] hart_group_i,
    input  logic [NUM_TRIG*HX_GRP_W-1:0]  trig_group_i,
    input  logic [NUM_HARTS-1:0]          hart_halted_i,
    input  logic [NUM_TRIG-1:0]           trig_in_i,
    output logic [NUM_HARTS-1:0]          halt_req_o,
    output logic [NUM_TRIG-1:0]           trig_out_o
);
    logic [NUM_HARTS-1:0] rise;
    logic [NUM_TRIG-1:0]  tin;
    logic [NUM_HARTS-1:0] hit;
    logic [NUM_TRIG-1:0]  fire;
    logic [NUM_TRIG-1:0]  trig_out_q;

    hx_edge #(.NUM_HARTS(NUM_HARTS), .NUM_TRIG(NUM_TRIG)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .halted_i (hart_halted_i),
        .trig_i   (trig_in_i),
        .rise_o   (rise),
        .trig_o   (tin)
    );

    hx_match #(.NUM_HARTS(NUM_HARTS), .NUM_TRIG(NUM_TRIG)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .hart_grp_i (hart_group_i),
        .trig_grp_i (trig_group_i),
        .rise_i     (rise),
        .tin_i      (tin),
        .hit_o      (hit),
        .fire_o     (fire)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_tgt
        hx_target #(.REARM_CYC(REARM_CYC)) u_tgt (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit_i    (hit[h]),
            .halted_i (hart_halted_i[h]),
            .req_o    (halt_req_o[h])
        );
    end

    // Register outgoing trigger pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_out_q <= '0;
        else
            trig_out_q <= fire;
    end

    assign trig_out_o = trig_out_q;

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_tchk
        // An outgoing pulse only leaves a line that was in a live group.
        AST_TRIG_LIVE_GRP: assert property (@(posedge clk) disable iff (!rst_n)
            trig_out_q[t] |-> ($past(trig_group_i[t*HX_GRP_W +: HX_GRP_W]) != HX_SOLO_GRP)); // R6
    end

    // Outputs are quiet in the first cycle after reset.
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (halt_req_o == '0 && trig_out_o == '0)); // R1

endmodule

// File: tb/halt_xtrig_tb.sv
module halt_xtrig_tb;
    localparam int NH = 4;
    localparam int NT = 2;
    localparam int GW = 5;
    localparam int RW = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NH*GW-1:0] hgrp = '0;
    logic [NT*GW-1:0] tgrp = '0;
    logic [NH-1:0]    halted = '0;
    logic [NT-1:0]    tin = '0;
    logic [NH-1:0]    req;
    logic [NT-1:0]    tout;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    halt_xtrig #(.NUM_HARTS(NH), .NUM_TRIG(NT), .REARM_CYC(RW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hart_group_i (hgrp),
        .trig_group_i (tgrp),
        .hart_halted_i(halted),
        .trig_in_i    (tin),
        .halt_req_o   (req),
        .trig_out_o   (tout)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        halted = '0;
        tin = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_pattern(input int p);
        for (int h = 0; h < NH; h++) hgrp[h*GW +: GW] = GW'((h * (p % 3) + p) % 3);
        for (int t = 0; t < NT; t++) tgrp[t*GW +: GW] = GW'((t + p) % 3);
    endtask

    function automatic logic [GW-1:0] hg(input int h);
        return hgrp[h*GW +: GW];
    endfunction

    function automatic logic [GW-1:0] tg(input int t);
        return tgrp[t*GW +: GW];
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NH-1:0] exp_req;
        logic [NT-1:0] exp_out;

        // R1: reset state, with a hart halted across reset.
        halted = 4'b0010;
        hgrp = {5'd1, 5'd1, 5'd1, 5'd1};
        tgrp = {5'd1, 5'd1};
        @(negedge clk); @(negedge clk);
        check("R1 req after reset", 32'(req), 0);
        check("R1 tout after reset", 32'(tout), 0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R1 no event from pre-reset halt", 32'(req), 0);
        check("R1 no trig from pre-reset halt", 32'(tout), 0);

        // R2, R5, R6, R9, R3: hart-sourced sweep.
        for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < NH; s++) begin
                do_reset();
                set_pattern(p);
                exp_req = '0;
                exp_out = '0;
                for (int h = 0; h < NH; h++)
                    if (h != s && hg(h) == hg(s) && hg(s) != 0) exp_req[h] = 1'b1;
                for (int t = 0; t < NT; t++)
                    if (tg(t) == hg(s) && hg(s) != 0) exp_out[t] = 1'b1;
                @(negedge clk);
                halted[s] = 1'b1;
                @(negedge clk);
                check("R2 no early request", 32'(req), 0);
                @(negedge clk);
                check("R2 group requests (R6 group 0, R9 no self)", 32'(req), 32'(exp_req));
                check("R5 trigger out pulse", 32'(tout), 32'(exp_out));
                @(negedge clk);
                check("R5 pulse one cycle", 32'(tout), 0);
                check("R3 request held", 32'(req), 32'(exp_req));
                if (exp_req != '0) begin
                    for (int h = 0; h < NH; h++) begin
                        if (exp_req[h]) begin
                            halted[h] = 1'b1;
                            @(negedge clk);
                            check("R3 request drops on halt", 32'(req[h]), 0);
                            break;
                        end
                    end
                end
            end
        end

        // R4, R6: trigger-sourced sweep.
        for (int p = 0; p < 8; p++) begin
            for (int t = 0; t < NT; t++) begin
                do_reset();
                set_pattern(p);
                exp_req = '0;
                for (int h = 0; h < NH; h++)
                    if (hg(h) == tg(t) && tg(t) != 0) exp_req[h] = 1'b1;
                @(negedge clk);
                tin[t] = 1'b1;
                @(negedge clk);
                tin[t] = 1'b0;
                @(negedge clk);
                check("R4 trigger requests (R6 group 0)", 32'(req), 32'(exp_req));
                check("R4 no trigger out from trigger in", 32'(tout), 0);
            end
        end

        // R7: group change creates no request; R9: halted hart shows no request.
        do_reset();
        hgrp = {5'd0, 5'd0, 5'd2, 5'd1};
        tgrp = {5'd0, 5'd0};
        @(negedge clk);
        halted[0] = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 other group untouched", 32'(req), 0);
        hgrp[1*GW +: GW] = 5'd1;
        repeat (4) @(negedge clk);
        check("R7 joining halted group no request", 32'(req), 0);

        // R8: race inside the window.
        do_reset();
        hgrp = {5'd0, 5'd0, 5'd0, 5'd3};
        tgrp = {5'd0, 5'd0};
        @(negedge clk);
        halted[1] = 1'b1;
        repeat (3) @(negedge clk);
        hgrp[1*GW +: GW] = 5'd3;
        @(negedge clk);
        halted[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 halted target no request", 32'(req[1]), 0);
        @(negedge clk);
        halted[1] = 1'b0;
        @(negedge clk);
        check("R8 resume race re-halts", 32'(req[1]), 1);
        @(negedge clk);
        check("R8 re-halt request held", 32'(req[1]), 1);

        // R8: window expired.
        do_reset();
        hgrp = {5'd0, 5'd0, 5'd0, 5'd3};
        @(negedge clk);
        halted[1] = 1'b1;
        repeat (3) @(negedge clk);
        hgrp[1*GW +: GW] = 5'd3;
        @(negedge clk);
        halted[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        repeat (RW + 1) @(negedge clk);
        halted[1] = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 late resume no request", 32'(req[1]), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule